// File: doc/BRIEF.md
# Variable-Page TLB Translation Lookup

This block translates a virtual address through a small, fully associative translation buffer whose entries each describe one page. The page size can differ per entry, from 1 KiB up to 16 MiB. A request carries a virtual address, an access type and a user/privileged flag. One clock later the block reports whether an entry matched, which entry it was, the physical address, the permissions granted and whether the access must fault.

Each entry holds a tag word, a data word and an 8-bit address-space ID. An ID of zero marks a global entry. A 32-bit zone protection word, indexed by a zone number held in the data word, can remove or widen the per-page permissions for user or privileged code. Entries are loaded through a plain write port, so a lookup can be checked against the contents it was given.

Top module: `vtlb_lookup`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rsp_valid`, `rsp_hit`, `rsp_fault`, `rsp_perm` and `rsp_paddr` are all zero.
- R2: A request accepted with `req_valid` high produces `rsp_valid` high on the next clock edge, with the results for that request. A cycle with no request gives `rsp_valid` low on the next edge.
- R3: Tag bits [9:7] hold the size code c, and the page size is 1024 << (2*c) bytes, so code 0 is 1 KiB and code 7 is 16 MiB. An entry matches only if its valid bit, tag bit 6, is set and tag bits [31:10] equal the request address once both are masked to the page frame.
- R4: An entry with a nonzero ID matches only when the ID equals `cur_pid`. An entry with ID 0 matches under any `cur_pid`.
- R5: When several entries match, the entry with the lowest index is reported on `rsp_idx`. Index 63 can be reported.
- R6: `rsp_paddr` takes the data-word page bits (bits [31:10]) above the page size and the request address bits below it.
- R7: The page permission set grants read always, write when data bit 8 is set and fetch when data bit 9 is set. `rsp_perm` bit 0 is read, bit 1 is write and bit 2 is fetch. Whenever any permission is granted, read is granted.
- R8: Data bits [7:4] select zone z, and its 2-bit code is `zone_prot[31-2z:30-2z]`. The codes act as follows. Code 0 grants nothing to user mode and gives the page set to privileged mode. Code 1 gives the page set to both modes. Code 2 gives the page set to user mode and full access to privileged mode. Code 3 gives full access to both modes.
- R9: The zone code is taken as 1 if the zone number is greater than `NUM_ZONES` (default 8), or if `ZONES_EN` is 0. Zone number `NUM_ZONES` itself still reads `zone_prot`.
- R10: `rsp_fault` is high on a miss, or when the access type (0 read, 1 write, 2 fetch) lacks its permission. Type 3 always faults.
- R11: On a miss, `rsp_hit`, `rsp_idx`, `rsp_perm` and `rsp_paddr` are zero.
- R12: A write to the entry store takes effect at the clock edge. A lookup in the same cycle as a write sees the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 6 | Entry index to load |
| wr_tag | input | 32 | Tag word: page number, size code, valid |
| wr_data | input | 32 | Data word: real page, fetch/write enables, zone |
| wr_tid | input | 8 | Address-space ID of the entry |
| cur_pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Zone protection word, 2 bits per zone |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_type | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for user mode, 0 for privileged |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | An entry matched |
| rsp_idx | output | 6 | Index of the winning entry |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted {fetch, write, read} |
| rsp_fault | output | 1 | Miss or access not permitted |

## Verification
An entry write and a lookup can fall in the same cycle. The lookup compares against the arrays as they stood before the clock edge. The bench provokes this by driving a load of a new valid entry and a request for that entry's page in the same cycle. It expects a miss on that response and a hit with the new index on the next request. Priority is judged in a similar way: two overlapping entries are loaded, the lower one wins, and after the lower one is invalidated the higher one is reported.

// File: rtl/vtlb_pkg.sv
`timescale 1ns/1ps
package vtlb_pkg;
  localparam int VA_W   = 32;
  localparam int MIN_SH = 10;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // Offset mask for a size code: page bytes minus one.
  function automatic logic [VA_W-1:0] off_mask(input logic [2:0] code);
    logic [VA_W-1:0] one_page;
    one_page = VA_W'(1024) << {code, 1'b0};
    return one_page - VA_W'(1);
  endfunction
endpackage

// File: rtl/vtlb_entry_match.sv
`timescale 1ns/1ps
module vtlb_entry_match
  import vtlb_pkg::*;
(
  input  logic                  vld,
  input  logic [VA_W-MIN_SH-1:0] epn,
  input  logic [2:0]            szc,
  input  logic [7:0]            tid,
  input  logic [7:0]            pid,
  input  logic [VA_W-1:0]       vaddr,
  output logic                  match
);
  logic [VA_W-1:0] frame_mask;
  logic            page_eq;
  logic            asid_ok;

  always_comb begin
    frame_mask = ~off_mask(szc);
    page_eq    = ((vaddr ^ {epn, {MIN_SH{1'b0}}}) & frame_mask) == '0;
    asid_ok    = (tid == 8'd0) || (tid == pid);
    match      = vld && page_eq && asid_ok;
  end
endmodule

// File: rtl/vtlb_prio_enc.sv
`timescale 1ns/1ps
module vtlb_prio_enc #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vtlb_perm.sv
`timescale 1ns/1ps
module vtlb_perm
  import vtlb_pkg::*;
#(
  parameter int NUM_ZONES = 8,
  parameter bit ZONES_EN  = 1'b1
) (
  input  logic [3:0]  zsel,
  input  logic        pg_wr,
  input  logic        pg_ex,
  input  logic [31:0] zone_prot,
  input  logic        user,
  input  logic [1:0]  acc,
  output logic [2:0]  perm,
  output logic        denied
);
  logic [4:0] zlsb;
  logic [1:0] zcode;
  logic [2:0] page_set;

  always_comb begin
    zlsb  = 5'd30 - {zsel, 1'b0};
    zcode = zone_prot[zlsb +: 2];
    if (!ZONES_EN || (int'(zsel) > NUM_ZONES)) zcode = 2'd1;

    page_set = {pg_ex, pg_wr, 1'b1};
    unique case (zcode)
      2'd0:    perm = user ? 3'b000 : page_set;
      2'd1:    perm = page_set;
      2'd2:    perm = user ? page_set : 3'b111;
      default: perm = 3'b111;
    endcase

    unique case (acc_e'(acc))
      ACC_READ:  denied = !perm[PERM_RD];
      ACC_WRITE: denied = !perm[PERM_WR];
      ACC_FETCH: denied = !perm[PERM_EX];
      default:   denied = 1'b1;
    endcase
  end
endmodule

// File: rtl/vtlb_lookup.sv
`timescale 1ns/1ps
module vtlb_lookup
  import vtlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int NUM_ZONES   = 8,
  parameter bit ZONES_EN    = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [5:0]  wr_idx,
  input  logic [31:0] wr_tag,
  input  logic [31:0] wr_data,
  input  logic [7:0]  wr_tid,
  input  logic [7:0]  cur_pid,
  input  logic [31:0] zone_prot,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_type,
  input  logic        req_user,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [5:0]  rsp_idx,
  output logic [31:0] rsp_paddr,
  output logic [2:0]  rsp_perm,
  output logic        rsp_fault
);
  localparam int IDX_W  = $clog2(NUM_ENTRIES);
  localparam int PN_W   = VA_W - MIN_SH;
  localparam int TAG_SW = PN_W + 3;     // page number + size code
  localparam int DAT_SW = PN_W + 6;     // real page + fetch + write + zone

  // Entry store, no reset on the arrays; validity is kept apart.
  logic [TAG_SW-1:0]      tag_mem [NUM_ENTRIES];
  logic [DAT_SW-1:0]      dat_mem [NUM_ENTRIES];
  logic [7:0]             tid_mem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] vld_q;

  logic unused_bits;
  assign unused_bits = ^{wr_tag[5:0], wr_data[3:0]};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx[IDX_W-1:0]] <= wr_tag[31:7];
      dat_mem[wr_idx[IDX_W-1:0]] <= wr_data[31:4];
      tid_mem[wr_idx[IDX_W-1:0]] <= wr_tid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx[IDX_W-1:0]] <= wr_tag[6];
  end

  // Parallel compare over all entries.
  logic [NUM_ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    vtlb_entry_match u_match (
      .vld   (vld_q[g]),
      .epn   (tag_mem[g][TAG_SW-1:3]),
      .szc   (tag_mem[g][2:0]),
      .tid   (tid_mem[g]),
      .pid   (cur_pid),
      .vaddr (req_vaddr),
      .match (match_vec[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] win_idx;

  vtlb_prio_enc #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req (match_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  // Winner decode.
  logic [TAG_SW-1:0] sel_tag;
  logic [DAT_SW-1:0] sel_dat;
  logic [VA_W-1:0]   sel_omask;
  logic [VA_W-1:0]   paddr_c;
  logic [2:0]        perm_c;
  logic              denied_c;

  always_comb begin
    sel_tag   = tag_mem[win_idx];
    sel_dat   = dat_mem[win_idx];
    sel_omask = off_mask(sel_tag[2:0]);
    paddr_c   = ({sel_dat[DAT_SW-1:6], {MIN_SH{1'b0}}} & ~sel_omask)
              | (req_vaddr & sel_omask);
  end

  vtlb_perm #(.NUM_ZONES(NUM_ZONES), .ZONES_EN(ZONES_EN)) u_perm (
    .zsel      (sel_dat[3:0]),
    .pg_wr     (sel_dat[4]),
    .pg_ex     (sel_dat[5]),
    .zone_prot (zone_prot),
    .user      (req_user),
    .acc       (req_type),
    .perm      (perm_c),
    .denied    (denied_c)
  );

  // Registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '0;
      rsp_paddr <= '0;
      rsp_perm  <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit   <= any_hit;
        rsp_idx   <= any_hit ? 6'(win_idx) : 6'd0;
        rsp_paddr <= any_hit ? paddr_c : '0;
        rsp_perm  <= any_hit ? perm_c : 3'b000;
        rsp_fault <= !any_hit || denied_c;
      end
    end
  end
endmodule

// File: rtl/vtlb_lookup_chk.sv
`timescale 1ns/1ps
module vtlb_lookup_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_vaddr,
  input logic [1:0]  req_type,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic [31:0] rsp_paddr,
  input logic [2:0]  rsp_perm,
  input logic        rsp_fault
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !rsp_valid && !rsp_hit && !rsp_fault);

  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_idle_no_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_offset_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> rsp_paddr[9:0] == $past(req_vaddr[9:0]));

  p_read_with_any_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_perm != 3'b000) |-> rsp_perm[0]);

  p_miss_faults_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> rsp_fault);

  p_write_granted_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit && $past(req_type) == 2'd1 && rsp_perm[1]) |-> !rsp_fault);

  p_miss_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_perm == 3'b000 && rsp_paddr == 32'd0));
endmodule

bind vtlb_lookup vtlb_lookup_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .req_type  (req_type),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_paddr (rsp_paddr),
  .rsp_perm  (rsp_perm),
  .rsp_fault (rsp_fault)
);

// File: tb/vtlb_lookup_tb_top.sv
`timescale 1ns/1ps
module vtlb_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_tag = '0, wr_data = '0;
  logic [7:0]  wr_tid = '0, cur_pid = 8'h05;
  logic [31:0] zone_prot = 32'h5555_5555;
  logic        req_valid = 1'b0, req_user = 1'b1;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_type = '0;

  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [5:0]  rsp_idx;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_perm;

  logic        nz_valid, nz_hit, nz_fault;
  logic [5:0]  nz_idx;
  logic [31:0] nz_paddr;
  logic [2:0]  nz_perm;

  int n_checks = 0;
  int n_errs   = 0;

  always #2.5 clk = ~clk;

  vtlb_lookup dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_data(wr_data), .wr_tid(wr_tid), .cur_pid(cur_pid), .zone_prot(zone_prot),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_type(req_type),
    .req_user(req_user), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_idx(rsp_idx), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .rsp_fault(rsp_fault));

  vtlb_lookup #(.ZONES_EN(1'b0)) dut_nz_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_data(wr_data), .wr_tid(wr_tid), .cur_pid(cur_pid), .zone_prot(zone_prot),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_type(req_type),
    .req_user(req_user), .rsp_valid(nz_valid), .rsp_hit(nz_hit),
    .rsp_idx(nz_idx), .rsp_paddr(nz_paddr), .rsp_perm(nz_perm),
    .rsp_fault(nz_fault));

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_tag(input logic [31:0] a, input logic [2:0] c, input logic v);
    return (a & 32'hFFFF_FC00) | (32'(c) << 7) | (32'(v) << 6);
  endfunction

  function automatic logic [31:0] mk_dat(input logic [31:0] r, input logic [3:0] z,
                                          input logic w, input logic x);
    return (r & 32'hFFFF_FC00) | (32'(x) << 9) | (32'(w) << 8) | (32'(z) << 4);
  endfunction

  function automatic logic [31:0] zp_with(input int z, input logic [1:0] c);
    logic [31:0] v;
    v = 32'h5555_5555;
    v[30 - 2*z +: 2] = c;
    return v;
  endfunction

  task automatic put(input int i, input logic [31:0] t, input logic [31:0] d, input logic [7:0] id);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(i); wr_tag = t; wr_data = d; wr_tid = id;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] ty, input logic us);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_type = ty; req_user = us;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string r, input logic h, input logic [5:0] ix,
                            input logic [31:0] pa, input logic [2:0] pm, input logic f);
    check({r, " valid"}, 32'(rsp_valid), 32'd1);
    check({r, " hit"},   32'(rsp_hit),   32'(h));
    check({r, " idx"},   32'(rsp_idx),   32'(ix));
    check({r, " paddr"}, rsp_paddr,      pa);
    check({r, " perm"},  32'(rsp_perm),  32'(pm));
    check({r, " fault"}, 32'(rsp_fault), 32'(f));
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid", 32'(rsp_valid), 0);
    check("R1 hit",   32'(rsp_hit),   0);
    check("R1 fault", 32'(rsp_fault), 0);
    check("R1 paddr", rsp_paddr,      0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_basic;
    put(3, mk_tag(32'h1000_0000, 3'd1, 1'b1), mk_dat(32'h8000_0000, 4'd0, 1'b1, 1'b0), 8'd0);
    lookup(32'h1000_0ABC, 2'd0, 1'b1);
    expect_rsp("R6 R7 basic read", 1, 6'd3, 32'h8000_0ABC, 3'b011, 0);
    @(posedge clk); #1;
    check("R2 idle", 32'(rsp_valid), 0);
    lookup(32'h1000_0ABC, 2'd2, 1'b1);
    expect_rsp("R10 fetch denied", 1, 6'd3, 32'h8000_0ABC, 3'b011, 1);
    lookup(32'h1000_0ABC, 2'd1, 1'b1);
    expect_rsp("R10 write ok", 1, 6'd3, 32'h8000_0ABC, 3'b011, 0);
    lookup(32'h1000_0ABC, 2'd3, 1'b0);
    expect_rsp("R10 type3", 1, 6'd3, 32'h8000_0ABC, 3'b011, 1);
    lookup(32'h1000_1000, 2'd0, 1'b1);
    expect_rsp("R11 R3 past 4K", 0, 6'd0, 32'h0, 3'b000, 1);
  endtask

  task automatic t_sizes;
    put(10, mk_tag(32'h4312_3400, 3'd7, 1'b1), mk_dat(32'h0A55_5400, 4'd0, 1'b0, 1'b1), 8'd0);
    put(11, mk_tag(32'h2000_0400, 3'd0, 1'b1), mk_dat(32'h3000_0C00, 4'd0, 1'b0, 1'b0), 8'd0);
    lookup(32'h43AB_CDEF, 2'd2, 1'b1);
    expect_rsp("R3 R6 16M page", 1, 6'd10, 32'h0AAB_CDEF, 3'b101, 0);
    lookup(32'h2000_07FF, 2'd0, 1'b1);
    expect_rsp("R3 R6 1K page", 1, 6'd11, 32'h3000_0FFF, 3'b001, 0);
    lookup(32'h2000_0800, 2'd0, 1'b1);
    expect_rsp("R3 1K bound", 0, 6'd0, 32'h0, 3'b000, 1);
    put(12, mk_tag(32'h2400_0000, 3'd2, 1'b0), mk_dat(32'h0, 4'd0, 1'b1, 1'b1), 8'd0);
    lookup(32'h2400_0010, 2'd0, 1'b1);
    expect_rsp("R3 invalid bit", 0, 6'd0, 32'h0, 3'b000, 1);
  endtask

  task automatic t_tid;
    put(20, mk_tag(32'h5000_0000, 3'd1, 1'b1), mk_dat(32'hE000_0000, 4'd0, 1'b1, 1'b1), 8'h07);
    lookup(32'h5000_0010, 2'd0, 1'b1);
    expect_rsp("R4 other pid", 0, 6'd0, 32'h0, 3'b000, 1);
    cur_pid = 8'h07;
    lookup(32'h5000_0010, 2'd0, 1'b1);
    expect_rsp("R4 own pid", 1, 6'd20, 32'hE000_0010, 3'b111, 0);
    lookup(32'h1000_0004, 2'd0, 1'b1);
    expect_rsp("R4 global", 1, 6'd3, 32'h8000_0004, 3'b011, 0);
  endtask

  task automatic t_prio;
    put(30, mk_tag(32'h6000_0000, 3'd1, 1'b1), mk_dat(32'hB000_0000, 4'd0, 1'b0, 1'b0), 8'd0);
    put(25, mk_tag(32'h6000_0000, 3'd1, 1'b1), mk_dat(32'hC000_0000, 4'd0, 1'b0, 1'b0), 8'd0);
    lookup(32'h6000_0123, 2'd0, 1'b1);
    expect_rsp("R5 low wins", 1, 6'd25, 32'hC000_0123, 3'b001, 0);
    put(25, mk_tag(32'h6000_0000, 3'd1, 1'b0), mk_dat(32'hC000_0000, 4'd0, 1'b0, 1'b0), 8'd0);
    lookup(32'h6000_0123, 2'd0, 1'b1);
    expect_rsp("R5 next wins", 1, 6'd30, 32'hB000_0123, 3'b001, 0);
    put(63, mk_tag(32'h7000_0000, 3'd1, 1'b1), mk_dat(32'h1200_0000, 4'd0, 1'b0, 1'b0), 8'd0);
    lookup(32'h7000_0FFC, 2'd0, 1'b1);
    expect_rsp("R5 top index", 1, 6'd63, 32'h1200_0FFC, 3'b001, 0);
  endtask

  task automatic t_zones;
    put(40, mk_tag(32'h9000_0000, 3'd1, 1'b1), mk_dat(32'hD000_0000, 4'd2, 1'b0, 1'b1), 8'd0);
    zone_prot = zp_with(2, 2'd0);
    lookup(32'h9000_0040, 2'd0, 1'b1);
    expect_rsp("R8 code0 user", 1, 6'd40, 32'hD000_0040, 3'b000, 1);
    check("R9 zones off perm",  32'(nz_perm),  32'b101);
    check("R9 zones off fault", 32'(nz_fault), 0);
    lookup(32'h9000_0040, 2'd1, 1'b0);
    expect_rsp("R8 code0 priv", 1, 6'd40, 32'hD000_0040, 3'b101, 1);
    zone_prot = zp_with(2, 2'd2);
    lookup(32'h9000_0040, 2'd2, 1'b1);
    expect_rsp("R8 code2 user", 1, 6'd40, 32'hD000_0040, 3'b101, 0);
    lookup(32'h9000_0040, 2'd1, 1'b0);
    expect_rsp("R8 code2 priv", 1, 6'd40, 32'hD000_0040, 3'b111, 0);
    zone_prot = zp_with(2, 2'd3);
    lookup(32'h9000_0040, 2'd1, 1'b1);
    expect_rsp("R8 code3 user", 1, 6'd40, 32'hD000_0040, 3'b111, 0);
    zone_prot = zp_with(2, 2'd1);
    lookup(32'h9000_0040, 2'd1, 1'b1);
    expect_rsp("R8 code1 user", 1, 6'd40, 32'hD000_0040, 3'b101, 1);
  endtask

  task automatic t_zone_range;
    put(41, mk_tag(32'h9100_0000, 3'd1, 1'b1), mk_dat(32'hD100_0000, 4'd12, 1'b0, 1'b0), 8'd0);
    put(42, mk_tag(32'h9200_0000, 3'd1, 1'b1), mk_dat(32'hD200_0000, 4'd8, 1'b0, 1'b0), 8'd0);
    zone_prot = zp_with(12, 2'd3);
    lookup(32'h9100_0008, 2'd1, 1'b1);
    expect_rsp("R9 zone above limit", 1, 6'd41, 32'hD100_0008, 3'b001, 1);
    zone_prot = zp_with(8, 2'd3);
    lookup(32'h9200_0008, 2'd1, 1'b1);
    expect_rsp("R9 zone at limit", 1, 6'd42, 32'hD200_0008, 3'b111, 0);
    check("R9 zones off at limit", 32'(nz_perm), 32'b001);
    zone_prot = 32'h5555_5555;
  endtask

  task automatic t_collide;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd50; wr_tid = 8'd0;
    wr_tag = mk_tag(32'hA000_0000, 3'd1, 1'b1);
    wr_data = mk_dat(32'hF000_0000, 4'd0, 1'b1, 1'b0);
    req_valid = 1'b1; req_vaddr = 32'hA000_0010; req_type = 2'd0; req_user = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; req_valid = 1'b0;
    expect_rsp("R12 same-cycle old view", 0, 6'd0, 32'h0, 3'b000, 1);
    lookup(32'h A000_0010, 2'd0, 1'b1);
    expect_rsp("R12 after write", 1, 6'd50, 32'hF000_0010, 3'b011, 0);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  endtask

  initial begin
    #500000;
    n_errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    t_reset();
    t_basic();
    t_sizes();
    t_tid();
    t_prio();
    t_zones();
    t_zone_range();
    t_collide();
    report();
  end
endmodule